// File: doc/BRIEF.md
# Two-Channel Pulse-Width Modulator with Clock Passthrough

This block generates up to two pulse-width modulated waveforms from a single module clock. Software programs it through a plain 32-bit register port: address, write data, write strobe and combinational read data. A shared control word holds every channel's settings. Each channel also has its own cycle/compare word, which sets the cycle length and the number of active ticks.

Each channel divides the module clock with a selectable prescaler to make counting ticks. A counter wraps after a programmable number of ticks. The output is at its active level while the count is below the compare value, and the active level is programmable. New cycle/compare values are held in a shadow copy and take effect only at a cycle boundary, and a per-channel ready flag shows whether a transfer is still outstanding. A passthrough bit sends the raw module clock straight to the channel output and overrides every other setting.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: After reset, the control word reads 0x3000_0000 (both ready flags set, every setting zero), the cycle/compare words read zero, and both outputs are high (the inactive level for an active-level bit of 0).
- R2: The control word is at byte address 0x0. Channel c's 10-bit field starts at bit 15*c and is laid out as: [3:0] prescaler code, 4 enable, 5 active level, 6 gate, 7 mode, 8 pulse, 9 passthrough. All ten bits read back as written. Control bits outside the fields and outside the ready flags read 0 whatever was written. Channel c's cycle/compare word is at byte address 0x4 + 4*c, with [31:16] holding the cycle length minus one and [15:0] holding the compare value, and it reads back the last value written.
- R3: A channel counts only while both gate and enable are 1. Otherwise its output is held at the inverse of its active level and its counter is held at zero, so a restart begins a fresh cycle.
- R4: While counting, a cycle lasts (cycle field + 1) ticks. The output is at its active level while the count is below the compare value. A compare of 0 keeps the output inactive for the whole cycle, and a compare above the cycle field keeps it active for the whole cycle.
- R5: An active-level bit of 1 makes the active level high. An active-level bit of 0 makes it low, which inverts the waveform.
- R6: Prescaler code 0xF gives one tick per module clock. Codes 0 to 9 divide by 120, 180, 240, 360, 480, 12000, 24000, 36000, 48000 and 72000. Codes 10 to 14 produce no ticks, so the counter and output freeze.
- R7: A write to a cycle/compare word lands in a shadow copy. While the channel is counting, the values in use change only at the end of the current cycle. While it is not counting, the transfer happens on the next clock. Ready flag c (control bit 28+c) reads 0 from the write until the transfer, then 1.
- R8: While passthrough is 1, the output equals the module clock regardless of enable, gate, prescaler, cycle or compare. The cycle in progress is abandoned and the counter is held at zero. When passthrough clears, counting restarts from zero.
- R9: The two channels run independently; settings and writes for one channel never alter the other channel's waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; also the passthrough source |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | Channel waveforms |

## Verification
The hardest situation to reach is a cycle/compare write that arrives while a cycle is running and completes just before or exactly at the wrap edge. Only then does the shadow transfer race the boundary and leave the ready flag low across cycles. Directed steps reprogram a running channel mid-cycle and read the ready flag at once. Many random writes with cycle fields of 0 to 7 then land on every phase of the counter, including the wrap cycle itself, and a lockstep bench model follows every edge to judge the output on both clock phases.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;

  localparam int DATA_W       = 32;
  localparam int CNT_W        = 16;
  localparam int PSEL_W       = 4;
  localparam int DIV_W        = 17;
  localparam int FIELD_W      = 10;
  localparam int FIELD_STRIDE = 15;
  localparam int READY_LSB    = 28;
  localparam int MAX_CH       = 2;

  // Per-channel settings, MSB first so the cast matches the control field.
  typedef struct packed {
    logic                byp;
    logic                pulse;
    logic                mode;
    logic                gate;
    logic                act;
    logic                en;
    logic [PSEL_W-1:0]   psel;
  } chan_cfg_t;

  // Module clocks per tick for a prescaler code; zero means the tick halts.
  function automatic logic [DIV_W-1:0] psel_divisor(input logic [PSEL_W-1:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      4'd0:    d = DIV_W'(120);
      4'd1:    d = DIV_W'(180);
      4'd2:    d = DIV_W'(240);
      4'd3:    d = DIV_W'(360);
      4'd4:    d = DIV_W'(480);
      4'd5:    d = DIV_W'(12000);
      4'd6:    d = DIV_W'(24000);
      4'd7:    d = DIV_W'(36000);
      4'd8:    d = DIV_W'(48000);
      4'd9:    d = DIV_W'(72000);
      4'd15:   d = DIV_W'(1);
      default: d = '0;
    endcase
    return d;
  endfunction

  // Output level of a channel from its counting state and compare value.
  function automatic logic drive_level(input logic running,
                                       input logic [CNT_W-1:0] count,
                                       input logic [CNT_W-1:0] compare,
                                       input logic active_hi);
    return (running && (count < compare)) ? active_hi : ~active_hi;
  endfunction

endpackage

// File: rtl/pwmd_regs.sv
module pwmd_regs
  import pwmd_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic                          bus_we,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_CH-1:0]             ch_ready,
  output chan_cfg_t [NUM_CH-1:0]        ch_cfg,
  output logic [NUM_CH-1:0][CNT_W-1:0]  sh_prd,
  output logic [NUM_CH-1:0][CNT_W-1:0]  sh_duty,
  output logic [NUM_CH-1:0]             sh_wr
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             ctrl_sel;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign ctrl_sel = (word_idx == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int LSB = c * FIELD_STRIDE;
    logic prd_sel;
    assign prd_sel  = (word_idx == IDX_W'(c + 1));
    assign sh_wr[c] = bus_we && prd_sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_cfg[c] <= '0;
      end else if (bus_we && ctrl_sel) begin
        ch_cfg[c] <= chan_cfg_t'(bus_wdata[LSB +: FIELD_W]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_prd[c]  <= '0;
        sh_duty[c] <= '0;
      end else if (sh_wr[c]) begin
        sh_prd[c]  <= bus_wdata[DATA_W-1 -: CNT_W];
        sh_duty[c] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (ctrl_sel) begin
      for (int c = 0; c < NUM_CH; c++) begin
        bus_rdata[c*FIELD_STRIDE +: FIELD_W] = ch_cfg[c];
        bus_rdata[READY_LSB + c]             = ch_ready[c];
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (word_idx == IDX_W'(c + 1)) begin
          bus_rdata = {sh_prd[c], sh_duty[c]};
        end
      end
    end
  end

endmodule

// File: rtl/pwmd_prescaler.sv
module pwmd_prescaler
  import pwmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] pcnt_q;
  logic             halted;

  assign div    = psel_divisor(psel);
  assign halted = (div == '0);
  assign tick   = run && !halted && (pcnt_q >= div - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (!run || tick) begin
      pcnt_q <= '0;
    end else if (!halted) begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwmd_channel.sv
module pwmd_channel
  import pwmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg,
  input  logic             tick,
  input  logic [CNT_W-1:0] sh_prd,
  input  logic [CNT_W-1:0] sh_duty,
  input  logic             sh_wr,
  output logic             run,
  output logic             level,
  output logic             ready,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] prd_act,
  output logic [CNT_W-1:0] duty_act
);

  logic             pend_q;
  logic             cyc_end;
  logic             load;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] prd_q;
  logic [CNT_W-1:0] duty_q;

  assign run     = cfg.gate && cfg.en && !cfg.byp;
  assign cyc_end = tick && (cnt_q >= prd_q);
  assign load    = pend_q && (!run || cyc_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cyc_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (sh_wr) begin
      pend_q <= 1'b1;
    end else if (load) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q  <= '0;
      duty_q <= '0;
    end else if (load) begin
      prd_q  <= sh_prd;
      duty_q <= sh_duty;
    end
  end

  assign level    = drive_level(run, cnt_q, duty_q, cfg.act);
  assign ready    = !pend_q;
  assign cnt      = cnt_q;
  assign prd_act  = prd_q;
  assign duty_act = duty_q;

endmodule

// File: rtl/pwm_dual_ctrl.sv
module pwm_dual_ctrl
  import pwmd_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  chan_cfg_t [NUM_CH-1:0]        ch_cfg;
  logic [NUM_CH-1:0][CNT_W-1:0]  sh_prd;
  logic [NUM_CH-1:0][CNT_W-1:0]  sh_duty;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_prd;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_duty;
  logic [NUM_CH-1:0]             sh_wr;
  logic [NUM_CH-1:0]             ch_ready;
  logic [NUM_CH-1:0]             ch_run;
  logic [NUM_CH-1:0]             ch_tick;
  logic [NUM_CH-1:0]             ch_level;
  logic [NUM_CH-1:0]             ch_act;
  logic [NUM_CH-1:0]             ch_byp;

  pwmd_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .ch_ready  (ch_ready),
    .ch_cfg    (ch_cfg),
    .sh_prd    (sh_prd),
    .sh_duty   (sh_duty),
    .sh_wr     (sh_wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwmd_prescaler u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ch_run[c]),
      .psel  (ch_cfg[c].psel),
      .tick  (ch_tick[c])
    );

    pwmd_channel u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (ch_cfg[c]),
      .tick     (ch_tick[c]),
      .sh_prd   (sh_prd[c]),
      .sh_duty  (sh_duty[c]),
      .sh_wr    (sh_wr[c]),
      .run      (ch_run[c]),
      .level    (ch_level[c]),
      .ready    (ch_ready[c]),
      .cnt      (ch_cnt[c]),
      .prd_act  (ch_prd[c]),
      .duty_act (ch_duty[c])
    );

    assign ch_act[c]  = ch_cfg[c].act;
    assign ch_byp[c]  = ch_cfg[c].byp;
    assign pwm_out[c] = ch_byp[c] ? clk : ch_level[c];
  end

endmodule

// File: rtl/pwmd_checker.sv
module pwmd_checker
  import pwmd_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            ch_run,
  input logic [NUM_CH-1:0]            ch_ready,
  input logic [NUM_CH-1:0]            ch_tick,
  input logic [NUM_CH-1:0]            ch_level,
  input logic [NUM_CH-1:0]            ch_act,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_prd,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_duty
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cnt[c] <= ch_prd[c]);                                              // R4
    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[c] && (ch_duty[c] > ch_prd[c])) |-> (ch_level[c] == ch_act[c])); // R4
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_run[c] |=> (ch_cnt[c] == '0));                                    // R3
    AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_run[c] |-> !ch_tick[c]);                                          // R6
    AST_IDLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_ready[c] && !ch_run[c]) |=> ch_ready[c]);                        // R7
    AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_ready[c] |=> ($stable(ch_prd[c]) && $stable(ch_duty[c])));         // R7
  end

endmodule

bind pwm_dual_ctrl pwmd_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ch_run   (ch_run),
  .ch_ready (ch_ready),
  .ch_tick  (ch_tick),
  .ch_level (ch_level),
  .ch_act   (ch_act),
  .ch_cnt   (ch_cnt),
  .ch_prd   (ch_prd),
  .ch_duty  (ch_duty)
);

// File: tb/tb_pwm_dual_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_dual_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic        b_we = 1'b0;
  logic [31:0] b_rdata;
  logic [1:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  pwm_dual_ctrl dut (
    .clk (clk), .rst_n (rst_n), .bus_addr (b_addr), .bus_wdata (b_wdata),
    .bus_we (b_we), .bus_rdata (b_rdata), .pwm_out (pwm_out)
  );

  // ---------------- reference model built from the requirements ----------
  logic [9:0]  m_cfg  [2];
  logic [15:0] m_sp   [2];
  logic [15:0] m_sd   [2];
  logic [15:0] m_ap   [2];
  logic [15:0] m_ad   [2];
  logic [15:0] m_cnt  [2];
  logic [31:0] m_pc   [2];
  logic        m_pend [2];

  function automatic int unsigned tb_div(input logic [3:0] k);
    int unsigned slow [10] = '{120, 180, 240, 360, 480, 12000, 24000, 36000, 48000, 72000};
    if (k == 4'hF) return 1;
    if (k < 4'd10) return slow[k];
    return 0;
  endfunction

  function automatic bit m_run(input int c);
    return m_cfg[c][6] && m_cfg[c][4] && !m_cfg[c][9];
  endfunction

  function automatic logic exp_pin(input int c, input logic phase);
    logic act;
    act = m_cfg[c][5];
    if (m_cfg[c][9]) return phase;
    if (m_run(c) && (m_cnt[c] < m_ad[c])) return act;
    return ~act;
  endfunction

  function automatic logic [31:0] exp_ctrl();
    logic [31:0] v = '0;
    for (int c = 0; c < 2; c++) begin
      v[c*15 +: 10] = m_cfg[c];
      v[28+c]       = !m_pend[c];
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cfg[c] <= '0; m_sp[c] <= '0; m_sd[c] <= '0; m_ap[c] <= '0;
        m_ad[c] <= '0; m_cnt[c] <= '0; m_pc[c] <= '0; m_pend[c] <= 1'b0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        automatic int unsigned d = tb_div(m_cfg[c][3:0]);
        automatic bit r   = m_run(c);
        automatic bit tk  = r && (d != 0) && (m_pc[c] + 1 >= d);
        automatic bit wrp = tk && (m_cnt[c] >= m_ap[c]);
        automatic bit ld  = m_pend[c] && (!r || wrp);
        automatic bit wsh = b_we && (b_addr[3:2] == 2'(c + 1));
        if (!r || tk) m_pc[c] <= 0; else if (d != 0) m_pc[c] <= m_pc[c] + 1;
        if (!r) m_cnt[c] <= '0;
        else if (tk) m_cnt[c] <= wrp ? 16'd0 : m_cnt[c] + 16'd1;
        if (ld) begin m_ap[c] <= m_sp[c]; m_ad[c] <= m_sd[c]; end
        if (wsh) begin
          m_sp[c] <= b_wdata[31:16]; m_sd[c] <= b_wdata[15:0]; m_pend[c] <= 1'b1;
        end else if (ld) begin
          m_pend[c] <= 1'b0;
        end
        if (b_we && b_addr[3:2] == 2'd0) m_cfg[c] <= b_wdata[c*15 +: 10];
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    b_addr = a; b_wdata = d; b_we = 1'b1;
    @(negedge clk);
    b_we = 1'b0;
  endtask

  task automatic rd_now(input logic [3:0] a, input logic [31:0] exp, input string tag);
    b_addr = a;
    #1;
    chk(b_rdata === exp, tag, b_rdata, exp);
  endtask

  task automatic idle(input int n, input string tag);
    cur_tag = tag;
    repeat (n) @(negedge clk);
  endtask

  // Pin monitor: both clock phases, after the model and design have settled.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (mon_on) for (int c = 0; c < 2; c++) begin
        automatic logic e = exp_pin(c, 1'b1);
        chk(pwm_out[c] === e, cur_tag, 32'(pwm_out[c]), 32'(e));
      end
      @(negedge clk); #2;
      if (mon_on) for (int c = 0; c < 2; c++) begin
        automatic logic e = exp_pin(c, 1'b0);
        chk(pwm_out[c] === e, cur_tag, 32'(pwm_out[c]), 32'(e));
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd_now(4'h0, 32'h3000_0000, "R1");
    rd_now(4'h4, 32'h0, "R1");
    rd_now(4'h8, 32'h0, "R1");
    #1 chk(pwm_out === 2'b11, "R1", 32'(pwm_out), 32'h3);
    mon_on = 1'b1;

    // R2: field layout, read-back, unused bits read zero
    cur_tag = "R2";
    wr(4'h0, 32'hFFFF_FFFF);
    rd_now(4'h0, 32'h31FF_83FF, "R2");
    wr(4'h0, 32'h0);
    rd_now(4'h0, 32'h3000_0000, "R2");
    wr(4'h8, 32'hABCD_0001);
    rd_now(4'h8, 32'hABCD_0001, "R2");
    wr(4'h4, 32'h1234_5678);
    rd_now(4'h4, 32'h1234_5678, "R2");

    // R7: idle channel transfers on the next clock
    wr(4'h4, 32'h0009_0003);
    rd_now(4'h0, 32'h2000_0000, "R7");
    @(negedge clk);
    rd_now(4'h0, 32'h3000_0000, "R7");

    // R4/R5/R3: waveform, polarity, gate and enable
    wr(4'h0, 32'h0000_007F); idle(45, "R4");
    wr(4'h0, 32'h0000_005F); idle(30, "R5");
    wr(4'h0, 32'h0000_006F); idle(15, "R3");
    wr(4'h0, 32'h0000_003F); idle(15, "R3");
    wr(4'h4, 32'h0005_0000); wr(4'h0, 32'h0000_007F); idle(25, "R4");
    wr(4'h4, 32'h0005_0009); idle(25, "R4");

    // R7: reprogram while running, ready low until the boundary
    wr(4'h4, 32'h0009_0003); idle(13, "R7");
    wr(4'h4, 32'h0003_0001);
    rd_now(4'h0, exp_ctrl(), "R7");
    chk(b_rdata[28] === 1'b0, "R7", 32'(b_rdata[28]), 32'h0);
    idle(30, "R7");
    rd_now(4'h0, exp_ctrl(), "R7");

    // R6: slow divisor and halted codes (gate cleared around code changes)
    wr(4'h0, 32'h0000_0030); wr(4'h4, 32'h0001_0001);
    wr(4'h0, 32'h0000_0070); idle(600, "R6");
    wr(4'h0, 32'h0000_0030); wr(4'h0, 32'h0000_007C); idle(80, "R6");
    wr(4'h0, 32'h0000_003F); wr(4'h0, 32'h0000_007F); idle(7, "R6");

    // R8: passthrough abandons the running cycle and restarts on exit
    wr(4'h4, 32'h0009_0004); idle(15, "R8");
    wr(4'h0, 32'h0000_027F); idle(20, "R8");
    wr(4'h0, 32'h0000_0260); idle(10, "R8");
    wr(4'h0, 32'h0000_007F); idle(30, "R8");

    // R9: second channel alongside the first
    wr(4'h8, 32'h0004_0002);
    wr(4'h0, 32'h003F_807F); idle(40, "R9");
    wr(4'h0, 32'h013F_807F); idle(20, "R9");

    // Random mix, everything judged by the lockstep model
    for (int i = 0; i < 1500; i++) begin
      automatic int op = $urandom_range(0, 9);
      cur_tag = "R9";
      if (op < 3) begin
        automatic logic [31:0] w = $urandom();
        for (int c = 0; c < 2; c++) begin
          automatic int p = $urandom_range(0, 11);
          w[c*15 +: 4] = (p < 9) ? 4'hF : (p == 9) ? 4'h0 : 4'(10 + $urandom_range(0, 4));
          w[c*15 + 9]  = ($urandom_range(0, 7) == 0);
        end
        wr(4'h0, w);
      end else if (op < 6) begin
        automatic logic [31:0] w;
        w[31:16] = 16'($urandom_range(0, 7));
        w[15:0]  = 16'($urandom_range(0, 9));
        wr($urandom_range(0, 1) ? 4'h8 : 4'h4, w);
        rd_now(4'h0, exp_ctrl(), "R7");
      end else if (op == 6) begin
        rd_now(4'h0, exp_ctrl(), "R2");
        rd_now(4'h4, {m_sp[0], m_sd[0]}, "R2");
        rd_now(4'h8, {m_sp[1], m_sd[1]}, "R2");
      end else begin
        idle($urandom_range(1, 12), "R4");
      end
    end
    idle(5, "R4");
    summary();
  end

endmodule